// File: doc/BRIEF.md
# Masked-Address Bit-Serial Frame Receiver

This block takes a serial bit stream for one 64 kbps channel, qualified by a strobe. In framed mode it finds flags and removes them, deletes stuffed zeros, checks the frame check sequence and keeps only frames whose two-byte address matches a reference. The comparison uses a per-bit mask, so masked bits never cause a mismatch. The bytes that follow the address and precede the check sequence, together with the address itself, go into a 128-byte receive FIFO that the host drains one byte at a time. In transparent mode every bit is packed into bytes and stored unchanged.

The host is told to drain the FIFO by a one-cycle message-ready interrupt. It fires when the fill level reaches a selectable threshold of 64 or 96 bytes. It also fires at the end of every accepted frame, together with a four-bit frame status. A 56 kbps option discards one bit slot in every eight. Frames whose check sequence fails are still stored, and the status word flags them.

Top module: `hdlc_rx_mask`

## Requirements
- R1: After reset rd_count is 0 and irq_rmr, frame_done and frame_stat are 0.
- R2: In framed mode (cfg_framed=1) the bytes of an accepted frame, counted from the first byte after the opening flag (0x7E, sent LSB first) up to but not including the two check-sequence bytes, are stored in arrival order. Each byte is assembled LSB first. Flags and the check sequence are never stored.
- R3: A 0 that follows five consecutive 1s in framed mode is removed before byte assembly, so payload bytes that contain runs of 1s are stored intact.
- R4: The first received byte is compared with cfg_addr[7:0] and the second with cfg_addr[15:8]. Bits where cfg_mask is 1 always match. A frame with a mismatch on an unmasked bit stores no byte and raises neither frame_done nor irq_rmr.
- R5: The check sequence is verified with the CRC-ITU-T polynomial (reflected 0x8408, preset 0xFFFF, good residue 0xF0B8). frame_stat[0] is 1 when the check fails.
- R6: Seven consecutive 1s inside an accepted frame end it with frame_stat[1]=1. Bytes already stored stay in the FIFO, and the receiver waits for a new flag.
- R7: A closing flag that arrives when the number of destuffed bits since the opening flag is not a multiple of 8 gives frame_stat[2]=1.
- R8: In transparent mode (cfg_framed=0) every accepted bit is packed LSB first, and each group of 8 is stored. There is no flag detection, destuffing, address filtering or frame_done.
- R9: With cfg_rate56=1 the eighth of every eight bit_valid strobes, counted from reset, is ignored.
- R10: irq_rmr pulses for one cycle when rd_count reaches 64 (cfg_thr_hi=0) or 96 (cfg_thr_hi=1).
- R11: Every end of an accepted frame pulses frame_done and irq_rmr for one cycle, whatever the fill level. frame_stat stays valid until the next frame end.
- R12: A byte written while the FIFO holds 128 bytes is dropped and rd_count stays 128. A drop during an accepted frame sets frame_stat[3] for that frame.
- R13: rd_en with rd_count>0 removes the oldest byte and presents it on rd_data one cycle later. rd_en with an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_framed | input | 1 | 1 = framed mode, 0 = transparent mode |
| cfg_rate56 | input | 1 | 1 = ignore one bit slot in eight |
| cfg_thr_hi | input | 1 | Interrupt threshold: 0 = 64 bytes, 1 = 96 bytes |
| cfg_addr | input | 16 | Reference address; low byte checked against the first byte |
| cfg_mask | input | 16 | Per-bit address mask, 1 = don't care |
| bit_valid | input | 1 | Strobe for one bit slot |
| bit_in | input | 1 | Serial data bit |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Byte popped by the previous rd_en |
| rd_count | output | 8 | FIFO fill level |
| irq_rmr | output | 1 | Message-ready pulse |
| frame_done | output | 1 | End-of-frame pulse |
| frame_stat | output | 4 | {overflow, misaligned, abort, check error} |

## Verification
The bench sends frames whose address differs only in a masked bit and others that differ in an unmasked bit. A filter that ignored the mask would drop the first kind, and one that skipped the comparison would store the second. Payloads full of 1s and check-sequence bytes that need stuffing catch a receiver that fails to delete stuffed zeros: it would store shifted bytes and report a check error. Further directed cases cover an abort after the address, a closing flag three bits off the byte boundary, both threshold crossings, and a frame that arrives with two free FIFO places. A design that got the abort case wrong would lose or invent stored bytes, a missing alignment check would leave frame_stat[2] clear, and off-by-one fill logic would fire the interrupt late or report no overflow. A 56 kbps transparent run with junk bits in the ignored slot shows whether the right slot is dropped.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam int          FLAG_ONES   = 6;

  typedef struct packed {
    logic ovf;
    logic misalign;
    logic abort;
    logic crc_err;
  } frm_stat_t;
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_framed,
  input  logic                  cfg_rate56,
  input  logic [2*BYTE_W-1:0]   cfg_addr,
  input  logic [2*BYTE_W-1:0]   cfg_mask,
  input  logic                  bit_valid,
  input  logic                  bit_in,
  output logic                  byte_wr,
  output logic [BYTE_W-1:0]     byte_data,
  output logic                  frame_open,
  output logic                  frame_end,
  output logic                  end_crc_err,
  output logic                  end_abort,
  output logic                  end_misalign
);
  localparam int SW   = $clog2(SLOTS);
  localparam int DLY  = FLAG_ONES + 1;
  localparam int OCW  = $clog2(DLY + 1);
  localparam int BCW  = $clog2(BYTE_W);
  localparam logic [SW-1:0]  DROP_SLOT = SW'(SLOTS - 1);
  localparam logic [BCW-1:0] LAST_BIT  = BCW'(BYTE_W - 1);

  logic [SW-1:0]      slot;
  logic [2:0]         ones;
  logic [DLY-1:0]     dly;
  logic [OCW-1:0]     occ;
  logic [BYTE_W-1:0]  asm_q, h0, h1;
  logic [BCW-1:0]     bitcnt;
  logic [1:0]         hc;
  logic               synced, accepted, addr_done;
  logic [15:0]        crc;

  logic take, is_flag, is_stuff, is_abort, push, pop, addr_ok;
  logic [BYTE_W-1:0] asm_n, tbyte;
  logic [15:0]       crc_n;

  always_comb begin
    take     = bit_valid && !(cfg_rate56 && slot == DROP_SLOT);
    is_flag  = !bit_in && ones == 3'(FLAG_ONES);
    is_stuff = !bit_in && ones == 3'(FLAG_ONES - 1);
    is_abort = bit_in && ones == 3'(FLAG_ONES);
    push     = bit_in ? (ones < 3'(FLAG_ONES)) : (ones < 3'(FLAG_ONES - 1));
    pop      = push && occ == OCW'(DLY);
    asm_n    = {dly[0], asm_q[BYTE_W-1:1]};
    tbyte    = {bit_in, asm_q[BYTE_W-1:1]};
    crc_n    = {1'b0, crc[15:1]} ^ ((crc[0] ^ dly[0]) ? CRC_POLY_R : 16'h0000);
    addr_ok  = ((({h1, h0} ^ cfg_addr) & ~cfg_mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0; ones <= '0; dly <= '0; occ <= '0; asm_q <= '0;
      h0 <= '0; h1 <= '0; bitcnt <= '0; hc <= '0; synced <= 1'b0;
      accepted <= 1'b0; addr_done <= 1'b0; crc <= CRC_PRESET;
      byte_wr <= 1'b0; byte_data <= '0; frame_open <= 1'b0; frame_end <= 1'b0;
      end_crc_err <= 1'b0; end_abort <= 1'b0; end_misalign <= 1'b0;
    end else begin
      byte_wr    <= 1'b0;
      frame_open <= 1'b0;
      frame_end  <= 1'b0;
      if (bit_valid) slot <= slot + SW'(1);
      if (take) begin
        if (!cfg_framed) begin
          synced <= 1'b0; accepted <= 1'b0; addr_done <= 1'b0;
          hc <= '0; occ <= '0;
          asm_q  <= tbyte;
          bitcnt <= bitcnt + BCW'(1);
          if (bitcnt == LAST_BIT) begin
            byte_wr   <= 1'b1;
            byte_data <= tbyte;
          end
        end else begin
          ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
          if (is_flag || is_abort) begin
            if (accepted) begin
              frame_end    <= 1'b1;
              end_crc_err  <= is_flag && (crc != CRC_RESIDUE);
              end_abort    <= is_abort;
              end_misalign <= is_flag && (bitcnt != '0);
            end
            synced <= is_flag; accepted <= 1'b0; addr_done <= 1'b0;
            hc <= '0; occ <= '0; bitcnt <= '0; crc <= CRC_PRESET;
          end else if (push) begin
            dly <= {bit_in, dly[DLY-1:1]};
            if (occ != OCW'(DLY)) occ <= occ + OCW'(1);
            if (pop) begin
              asm_q  <= asm_n;
              bitcnt <= bitcnt + BCW'(1);
              crc    <= crc_n;
              if (bitcnt == LAST_BIT) begin
                case (hc)
                  2'd0:    begin h0 <= asm_n; hc <= 2'd1; end
                  2'd1:    begin h1 <= asm_n; hc <= 2'd2; end
                  default: begin
                    h0 <= h1;
                    h1 <= asm_n;
                    if (synced) begin
                      if (!addr_done) begin
                        addr_done <= 1'b1;
                        if (addr_ok) begin
                          accepted   <= 1'b1;
                          frame_open <= 1'b1;
                          byte_wr    <= 1'b1;
                          byte_data  <= h0;
                        end
                      end else if (accepted) begin
                        byte_wr   <= 1'b1;
                        byte_data <= h0;
                      end
                    end
                  end
                endcase
              end
            end
          end
        end
      end
    end
  end

  // R9: the ignored slot leaves the byte assembly and run counter untouched
  assert_slot_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && cfg_rate56 && slot == DROP_SLOT) |=> ($stable(bitcnt) && $stable(ones)));

  // R4: in framed mode only an accepted frame may write the FIFO
  assert_write_needs_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && cfg_framed && $past(cfg_framed)) |-> accepted);

  // R8: no frame end is reported while transparent
  assert_no_end_transparent_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_framed && !$past(cfg_framed)) |-> !frame_end);
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 8,
  parameter int THR_LO = 64,
  parameter int THR_HI = 96
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [BYTE_W-1:0]               wd,
  input  logic                            rd,
  input  logic                            thr_hi,
  output logic [BYTE_W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0]      count,
  output logic                            thr_pulse,
  output logic                            drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              full, wr_ok, rd_ok;
  logic [CW-1:0]     cnt_n, thr;

  always_comb begin
    full  = count == CW'(DEPTH);
    wr_ok = wr && !full;
    rd_ok = rd && count != '0;
    drop  = wr && full;
    cnt_n = count + CW'(wr_ok) - CW'(rd_ok);
    thr   = thr_hi ? CW'(THR_HI) : CW'(THR_LO);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; rptr <= '0; count <= '0; rd_data <= '0; thr_pulse <= 1'b0;
    end else begin
      count     <= cnt_n;
      thr_pulse <= (cnt_n == thr) && (count != thr);
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) begin
        rd_data <= mem[rptr];
        rptr    <= rptr + AW'(1);
      end
    end
  end

  // R12: fill level never exceeds the depth and holds when full
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (full && wr && !rd) |=> (count == CW'(DEPTH)));

  // R13: a read of an empty FIFO changes nothing
  assert_empty_read_R13: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && rd && !wr) |=> (count == '0 && $stable(rd_data)));
endmodule

// File: rtl/hdlc_rx_mask.sv
module hdlc_rx_mask
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int BYTE_W     = 8,
  parameter int THR_LO     = 64,
  parameter int THR_HI     = 96,
  parameter int SLOTS      = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_framed,
  input  logic                             cfg_rate56,
  input  logic                             cfg_thr_hi,
  input  logic [2*BYTE_W-1:0]              cfg_addr,
  input  logic [2*BYTE_W-1:0]              cfg_mask,
  input  logic                             bit_valid,
  input  logic                             bit_in,
  input  logic                             rd_en,
  output logic [BYTE_W-1:0]                rd_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  rd_count,
  output logic                             irq_rmr,
  output logic                             frame_done,
  output logic [3:0]                       frame_stat
);
  logic              byte_wr, frame_open, frame_end;
  logic              end_crc_err, end_abort, end_misalign;
  logic [BYTE_W-1:0] byte_data;
  logic              thr_pulse, drop, ovf_seen;
  frm_stat_t         stat_q;

  hdlc_rx_deframer #(.BYTE_W(BYTE_W), .SLOTS(SLOTS)) u_deframer (
    .clk(clk), .rst(rst), .cfg_framed(cfg_framed), .cfg_rate56(cfg_rate56),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .bit_valid(bit_valid), .bit_in(bit_in),
    .byte_wr(byte_wr), .byte_data(byte_data), .frame_open(frame_open),
    .frame_end(frame_end), .end_crc_err(end_crc_err), .end_abort(end_abort),
    .end_misalign(end_misalign)
  );

  hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH), .BYTE_W(BYTE_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_fifo (
    .clk(clk), .rst(rst), .wr(byte_wr), .wd(byte_data), .rd(rd_en), .thr_hi(cfg_thr_hi),
    .rd_data(rd_data), .count(rd_count), .thr_pulse(thr_pulse), .drop(drop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_seen   <= 1'b0;
      stat_q     <= '0;
      frame_done <= 1'b0;
      irq_rmr    <= 1'b0;
    end else begin
      if (frame_open)  ovf_seen <= drop;
      else if (drop)   ovf_seen <= 1'b1;
      frame_done <= frame_end;
      irq_rmr    <= thr_pulse || frame_end;
      if (frame_end) begin
        stat_q.ovf      <= ovf_seen;
        stat_q.misalign <= end_misalign;
        stat_q.abort    <= end_abort;
        stat_q.crc_err  <= end_crc_err;
      end
    end
  end

  assign frame_stat = stat_q;

  // R1: the cycle after reset shows an empty FIFO and quiet outputs
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_count == '0 && !irq_rmr && !frame_done));

  // R11: every frame end is accompanied by the message-ready pulse
  assert_end_irq_R11: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> irq_rmr);
endmodule

// File: tb/hdlc_rx_mask_tb.sv
`timescale 1ns/1ps
module hdlc_rx_mask_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_framed = 1'b1, cfg_rate56 = 1'b0, cfg_thr_hi = 1'b0;
  logic [15:0] cfg_addr = 16'h1234, cfg_mask = 16'h0100;
  logic bit_valid = 1'b0, bit_in = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data, rd_count;
  logic irq_rmr, frame_done;
  logic [3:0] frame_stat;

  int nchk = 0, nfail = 0, cyc = 0, irq_cnt = 0, done_cnt = 0, st_ones = 0;
  logic [7:0] fb [0:15];

  always #4 clk = ~clk;

  hdlc_rx_mask u_dut (
    .clk(clk), .rst(rst), .cfg_framed(cfg_framed), .cfg_rate56(cfg_rate56),
    .cfg_thr_hi(cfg_thr_hi), .cfg_addr(cfg_addr), .cfg_mask(cfg_mask),
    .bit_valid(bit_valid), .bit_in(bit_in), .rd_en(rd_en), .rd_data(rd_data),
    .rd_count(rd_count), .irq_rmr(irq_rmr), .frame_done(frame_done), .frame_stat(frame_stat)
  );

  always @(posedge clk) begin
    if (!rst && irq_rmr) irq_cnt++;
    if (!rst && frame_done) done_cnt++;
    cyc++;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // {a0, a1, payload len, seed, bad check, expect accepted}
  localparam logic [33:0] VEC [6] = '{
    {8'h34, 8'h12, 8'd3, 8'h5A, 1'b0, 1'b1},
    {8'h34, 8'h13, 8'd3, 8'h5A, 1'b0, 1'b1},
    {8'h35, 8'h12, 8'd3, 8'h5A, 1'b0, 1'b0},
    {8'h34, 8'h12, 8'd4, 8'hFF, 1'b0, 1'b1},
    {8'h34, 8'h12, 8'd2, 8'h3C, 1'b1, 1'b1},
    {8'h34, 8'h12, 8'd0, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic send_flag();
    send_bit(0); for (int i = 0; i < 6; i++) send_bit(1); send_bit(0);
    st_ones = 0;
  endtask

  task automatic put_stuffed(input logic b);
    send_bit(b);
    if (b) begin
      st_ones++;
      if (st_ones == 5) begin send_bit(0); st_ones = 0; end
    end else st_ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_stuffed(v[i]);
  endtask

  task automatic send_raw_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_frame(input int n, input bit bad, input int extra);
    logic [15:0] crc;
    crc = 16'hFFFF;
    send_flag();
    for (int k = 0; k < n; k++) begin
      put_byte(fb[k]);
      for (int i = 0; i < 8; i++) begin
        logic fbk;
        fbk = crc[0] ^ fb[k][i];
        crc = crc >> 1;
        if (fbk) crc = crc ^ 16'h8408;
      end
    end
    crc = ~crc;
    if (bad) crc = crc ^ 16'h0001;
    put_byte(crc[7:0]);
    put_byte(crc[15:8]);
    for (int i = 0; i < extra; i++) put_stuffed(0);
    send_flag();
    send_flag();
  endtask

  task automatic read_chk(input string tag, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [7:0] tbyte(input int k);
    if (k == 5) return 8'h7E;
    if (k == 6) return 8'hFF;
    return 8'(k * 3 + 1);
  endfunction

  initial begin
    int i0, d0, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset count", rd_count, 0);
    chk("R1 reset irq", irq_rmr, 0);
    chk("R1 reset done", frame_done, 0);
    chk("R1 reset status", frame_stat, 0);
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; settle();
    chk("R13 read empty count", rd_count, 0);
    chk("R13 read empty data", rd_data, 0);

    // Table of framed vectors: R2 R3 R4 R5 R11
    for (int v = 0; v < 6; v++) begin
      logic [33:0] e;
      e = VEC[v];
      n = int'(e[17:10]);
      fb[0] = e[33:26]; fb[1] = e[25:18];
      for (int k = 0; k < n; k++) fb[k+2] = e[9:2] ^ 8'(k * 8'h11);
      i0 = irq_cnt; d0 = done_cnt;
      send_frame(n + 2, e[1], 0);
      settle();
      chk($sformatf("R4 vec%0d stored count", v), rd_count, e[0] ? n + 2 : 0);
      chk($sformatf("R11 vec%0d frame_done", v), done_cnt - d0, e[0] ? 1 : 0);
      chk($sformatf("R11 vec%0d irq", v), irq_cnt - i0, e[0] ? 1 : 0);
      if (e[0]) begin
        chk($sformatf("R5 vec%0d status", v), frame_stat, {3'b000, e[1]});
        for (int k = 0; k < n + 2; k++)
          read_chk($sformatf("R2 R3 vec%0d byte%0d", v, k), fb[k]);
      end
    end

    // R6 abort after address and payload
    fb[0] = 8'h34; fb[1] = 8'h12; fb[2] = 8'h01; fb[3] = 8'h10; fb[4] = 8'h23;
    d0 = done_cnt;
    send_flag();
    for (int k = 0; k < 5; k++) put_byte(fb[k]);
    for (int i = 0; i < 8; i++) send_bit(1);
    send_flag();
    settle();
    chk("R6 abort done", done_cnt - d0, 1);
    chk("R6 abort status", frame_stat, 4'b0010);
    chk("R6 abort kept count", rd_count, 2);
    read_chk("R6 abort byte0", 8'h34);
    read_chk("R6 abort byte1", 8'h12);

    // R7 closing flag off the byte boundary
    fb[0] = 8'h34; fb[1] = 8'h12; fb[2] = 8'hAA; fb[3] = 8'h55;
    send_frame(4, 0, 3);
    settle();
    chk("R7 misalign flag", frame_stat & 4'b0100, 4'b0100);
    chk("R7 misalign count", rd_count, 4);
    for (int k = 0; k < 4; k++) read_chk("R7 misalign data", fb[k]);

    // R8 transparent, R10 thresholds, R12 overflow
    cfg_framed = 1'b0; cfg_thr_hi = 1'b0;
    i0 = irq_cnt; d0 = done_cnt;
    for (int k = 0; k < 64; k++) send_raw_byte(tbyte(k));
    settle();
    chk("R10 count at 64", rd_count, 64);
    chk("R10 irq at 64", irq_cnt - i0, 1);
    cfg_thr_hi = 1'b1;
    for (int k = 64; k < 95; k++) send_raw_byte(tbyte(k));
    settle();
    chk("R10 no irq at 95", irq_cnt - i0, 1);
    send_raw_byte(tbyte(95));
    settle();
    chk("R10 irq at 96", irq_cnt - i0, 2);
    for (int k = 96; k < 130; k++) send_raw_byte(tbyte(k));
    settle();
    chk("R12 full count", rd_count, 128);
    chk("R8 no frame_done", done_cnt - d0, 0);
    read_chk("R8 raw byte0", tbyte(0));
    read_chk("R8 raw byte1", tbyte(1));
    cfg_framed = 1'b1;
    fb[0] = 8'h34; fb[1] = 8'h12; fb[2] = 8'hC3; fb[3] = 8'h3C;
    send_frame(4, 0, 0);
    settle();
    chk("R12 overflow status", frame_stat, 4'b1000);
    chk("R12 count after frame", rd_count, 128);
    for (int k = 2; k < 128; k++) read_chk($sformatf("R8 raw byte%0d", k), tbyte(k));
    read_chk("R12 kept addr0", 8'h34);
    read_chk("R12 kept addr1", 8'h12);
    chk("R13 drained", rd_count, 0);

    // R9 56 kbps transparent after a fresh reset
    @(negedge clk); rst = 1'b1; cfg_framed = 1'b0; cfg_rate56 = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 second reset count", rd_count, 0);
    fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h0F; fb[3] = 8'hF0;
    fb[4] = 8'h81; fb[5] = 8'h7E; fb[6] = 8'hC3;
    begin
      int dbit;
      dbit = 0;
      for (int s = 0; s < 64; s++) begin
        if (s % 8 == 7) send_bit(s[3]);
        else begin send_bit(fb[dbit / 8][dbit % 8]); dbit++; end
      end
    end
    settle();
    chk("R9 56k count", rd_count, 7);
    for (int k = 0; k < 7; k++) read_chk($sformatf("R9 56k byte%0d", k), fb[k]);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule